// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block decides the cycle in which a simple pipelined processor takes its single external interrupt, and it issues the control actions for that event. The external request line passes through a synchronizer first. The request is then weighed against four conditions: the interrupt-enable and break-in-progress status bits, whether the decode stage holds a valid instruction, and whether the pipeline is ready to advance.

When the request is accepted, the instruction in the execute stage is left to finish. The instruction in decode is squashed, and a branch to the fixed vector address 0x10 is requested. The decode-stage PC is written as the return address into general-purpose register 14, and the status logic is asked to clear interrupt-enable. All four actions are one-cycle strobes in the same cycle. After an acceptance, the unit stays disarmed until it sees interrupt-enable go from 0 back to 1. A handler must therefore re-enable interrupts before it can be interrupted again.

Top module: `irq_accept_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), flush_dec, br_req, rf_we and ie_clr are all 0.
- R2: While stat_ie is 0, no acceptance occurs. A request still asserted when stat_ie returns to 1 is accepted.
- R3: While stat_bip is 1, no acceptance occurs. A request still asserted when stat_bip returns to 0 is accepted.
- R4: An acceptance raises flush_dec, br_req, rf_we and ie_clr together for exactly one cycle. In that cycle br_target is 0x10, rf_waddr is 14 and rf_wdata equals dec_pc.
- R5: irq_in is sampled through two flops. A request raised between clock edges, with every condition allowing, shows no strobe after the first rising edge and shows the strobes after the second.
- R6: An acceptance is held off while dec_valid is 0 or pipe_ready is 0. It happens in the first cycle in which both are 1 and the request is still asserted.
- R7: After an acceptance, no further acceptance occurs while stat_ie stays 1. Once stat_ie has been seen at 0 and then at 1, acceptance is re-armed starting from the cycle after the one in which stat_ie reads 1 again.
- R8: The request is level-sensitive. A request that drops before it could be accepted leaves no acceptance behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 1 | Asynchronous external interrupt request, active high |
| stat_ie | input | 1 | Interrupt-enable bit of the status register |
| stat_bip | input | 1 | Break-in-progress bit of the status register |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_pc | input | ADDR_W | PC of the decode-stage instruction |
| pipe_ready | input | 1 | Pipeline is not stalled this cycle |
| flush_dec | output | 1 | Squash the decode-stage instruction |
| br_req | output | 1 | Branch request to the vector |
| br_target | output | ADDR_W | Branch target, the fixed vector 0x10 |
| rf_we | output | 1 | Register-file write strobe for the return address |
| rf_waddr | output | REG_W | Register index written, fixed at 14 |
| rf_wdata | output | ADDR_W | Return address, equal to dec_pc |
| ie_clr | output | 1 | Request to clear the interrupt-enable bit |

## Verification
A raised request is due two rising edges after it is driven. A condition that changes while a synchronized request is waiting takes effect in the same cycle, because the gating is combinational. Re-arming after stat_ie rises takes one rising edge. The bench drives every input just after a falling edge. It samples one nanosecond later when it expects a combinational response, and after the matching number of rising edges when it expects a registered one. It also checks the cycle just before each expected strobe and the cycle just after it, which pins the latency and the one-cycle width.

// File: rtl/irq_accept_pkg.sv
// Shared types for the interrupt acceptance unit.
// Assumes: all status inputs are already synchronous to clk.
package irq_accept_pkg;

    // Conditions that gate acceptance, bundled for the gate module.
    typedef struct packed {
        logic req;      // synchronized request
        logic ie;       // interrupt enable
        logic bip;      // break in progress
        logic dvalid;   // decode stage valid
        logic ready;    // pipeline ready
    } irq_cond_t;

endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchronizer for the asynchronous interrupt line.
// Assumes: STAGES >= 2; the output is a level, not an edge.
module irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];

    assert_stage0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain[0]) |-> $past(d));
    assert_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(chain[LAST-1]));
endmodule

// File: rtl/irq_gate.sv
// Acceptance decision with the re-arm guard.
// Assumes: the processor clears ie after an acceptance, and software sets it again.
module irq_gate
    import irq_accept_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  irq_cond_t cond,
    output logic      take
);
    logic armed;
    logic ie_q;

    // Accept when requested, enabled, not in break, the slot is valid and not stalled.
    always_comb begin
        take = cond.req && cond.ie && !cond.bip && cond.dvalid && cond.ready && armed;
    end

    // Disarm on acceptance; re-arm on an observed 0-to-1 step of ie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            ie_q  <= 1'b0;
        end else begin
            ie_q <= cond.ie;
            if (take)                   armed <= 1'b0;
            else if (cond.ie && !ie_q)  armed <= 1'b1;
        end
    end

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !armed);
    assert_stay_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !(cond.ie && !ie_q)) |=> !armed);
endmodule

// File: rtl/irq_action.sv
// Fans the acceptance decision out to the pipeline control strobes.
// Assumes: target and link index are fixed by parameters.
module irq_action #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REG_W  = 5,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 'h10,
    parameter int unsigned LINK_IDX = 14
) (
    input  logic              take,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              flush,
    output logic              branch,
    output logic [ADDR_W-1:0] target,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] wr_val,
    output logic              clr_ie
);
    localparam logic [REG_W-1:0] LINK = REG_W'(LINK_IDX);

    // Drive all acceptance strobes and their payloads in one cycle.
    always_comb begin
        flush  = take;
        branch = take;
        wr_en  = take;
        clr_ie = take;
        target = VEC_ADDR;
        wr_idx = LINK;
        wr_val = pc_in;
    end
endmodule

// File: rtl/irq_accept_unit.sv
// Top of the interrupt acceptance unit: synchronizer, gate, action fan-out.
// Assumes: status and pipeline inputs are synchronous; irq_in may be asynchronous.
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned REG_W       = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 'h10,
    parameter int unsigned LINK_IDX    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              stat_ie,
    input  logic              stat_bip,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              pipe_ready,
    output logic              flush_dec,
    output logic              br_req,
    output logic [ADDR_W-1:0] br_target,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [ADDR_W-1:0] rf_wdata,
    output logic              ie_clr
);
    logic      req_s;
    logic      take;
    irq_cond_t cond;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(req_s)
    );

    // Bundle the gating conditions.
    always_comb begin
        cond.req    = req_s;
        cond.ie     = stat_ie;
        cond.bip    = stat_bip;
        cond.dvalid = dec_valid;
        cond.ready  = pipe_ready;
    end

    irq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cond(cond), .take(take)
    );

    irq_action #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .VEC_ADDR(VEC_ADDR), .LINK_IDX(LINK_IDX)
    ) u_action (
        .take(take), .pc_in(dec_pc),
        .flush(flush_dec), .branch(br_req), .target(br_target),
        .wr_en(rf_we), .wr_idx(rf_waddr), .wr_val(rf_wdata), .clr_ie(ie_clr)
    );

    assert_ie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_ie |-> !flush_dec);
    assert_bip_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_bip |-> !ie_clr);
    assert_ret_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata == dec_pc && rf_waddr == REG_W'(LINK_IDX)));
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dec |=> !flush_dec);
    assert_slot_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_req |-> (dec_valid && pipe_ready));
endmodule

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n, irq_in, stat_ie, stat_bip, dec_valid, pipe_ready;
    logic [31:0] dec_pc;
    logic        flush_dec, br_req, rf_we, ie_clr;
    logic [31:0] br_target, rf_wdata;
    logic [4:0]  rf_waddr;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .stat_ie(stat_ie),
        .stat_bip(stat_bip), .dec_valid(dec_valid), .dec_pc(dec_pc),
        .pipe_ready(pipe_ready), .flush_dec(flush_dec), .br_req(br_req),
        .br_target(br_target), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .ie_clr(ie_clr)
    );

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // Checks the strobes (all or none) and, when taken, the payload.
    task automatic expect_take(string req, bit exp);
        logic [3:0] got = {flush_dec, br_req, rf_we, ie_clr};
        logic [3:0] want = exp ? 4'hF : 4'h0;
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s strobes act=%b exp=%b", req, got, want);
        end
        if (exp) begin
            n_run++;
            if (br_target !== 32'h10 || rf_waddr !== 5'd14 || rf_wdata !== dec_pc) begin
                n_fail++;
                $display("FAIL %s payload act=%h/%0d/%h exp=00000010/14/%h",
                         req, br_target, rf_waddr, rf_wdata, dec_pc);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 0; irq_in = 0; stat_ie = 0; stat_bip = 0;
        dec_valid = 0; pipe_ready = 0; dec_pc = '0;
        @(negedge clk);
        do_reset();
        #1 expect_take("R1", 0);

        // Sweep all 16 gating combinations with the request raised.
        for (int c = 0; c < 16; c++) begin
            bit e, b, v, r, exp;
            e = c[3]; b = c[2]; v = c[1]; r = c[0];
            stat_ie = 0; stat_bip = 0; dec_valid = 0; pipe_ready = 0;
            do_reset();
            stat_ie = e; stat_bip = b; dec_valid = v; pipe_ready = r;
            dec_pc = 32'h1000 + 32'(c) * 4;
            step();
            irq_in = 1'b1;
            exp = e && !b && v && r;
            step();
            expect_take("R5", 0);
            step();
            if (!e)      expect_take("R2", exp);
            else if (b)  expect_take("R3", exp);
            else         expect_take("R6", exp);
            if (exp) begin
                step();
                expect_take("R4", 0);
                step();
                expect_take("R7", 0);
            end else begin
                stat_ie = 1; stat_bip = 0; dec_valid = 1; pipe_ready = 1;
                #1;
                if (!e)      expect_take("R2", 1);
                else if (b)  expect_take("R3", 1);
                else         expect_take("R6", 1);
                step();
                expect_take("R4", 0);
            end
        end

        // Re-arm: ie low then high re-enables acceptance one edge later.
        stat_ie = 0;
        step();
        expect_take("R2", 0);
        stat_ie = 1;
        #1 expect_take("R7", 0);
        step();
        expect_take("R7", 1);
        step();
        expect_take("R7", 0);

        // Level sensitivity: a short request while disabled leaves nothing.
        stat_ie = 0; irq_in = 0;
        do_reset();
        irq_in = 1; step(); irq_in = 0;
        step(); step();
        stat_ie = 1; stat_bip = 0; dec_valid = 1; pipe_ready = 1;
        #1 expect_take("R8", 0);
        step();
        expect_take("R8", 0);
        step();
        expect_take("R8", 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule